// File: doc/BRIEF.md
# Two-Wire Bus Slave Address Recognizer

This block sits behind a two-wire serial bus front end. It decides, after each START, whether the local slave is being addressed and by which kind of address. The front end supplies single-cycle event strobes: a START (first or repeated), a STOP, and a strobe for each complete received byte. The block looks at the first byte, and for 10-bit addressing also at the second. It recognises four cases: its own 7-bit address, its own 10-bit address, the general call and the START byte. It turns away every other reserved code. For each address byte it returns an acknowledge decision for the ninth clock, one cycle after the byte strobe. It also reports the match type and the transfer direction, which stay valid until the next START or STOP.

The control is a five-state machine:
- ST_IDLE waits for a START.
- ST_ADDR1 waits for the first address byte.
- ST_ADDR2 waits for the low byte of a 10-bit address.
- ST_SELECTED means the slave is addressed and data bytes pass by.
- ST_IGNORE means the slave has declined and waits for the next START.

The transitions are:
- T_STOP: any state goes to ST_IDLE on a STOP.
- T_START: any state goes to ST_ADDR1 on a START.
- T_HIT: ST_ADDR1 goes to ST_SELECTED on a 7-bit match, an enabled general call, or a 10-bit read header while a 10-bit match is held.
- T_HDR: ST_ADDR1 goes to ST_ADDR2 on a matching 10-bit write header.
- T_LOW_HIT: ST_ADDR2 goes to ST_SELECTED when the low address byte matches.
- T_MISS: ST_ADDR1 or ST_ADDR2 goes to ST_IGNORE on any other byte.

A separate hold flag records a completed 10-bit write match. A later repeated START followed by the read header then re-selects the slave without resending the low byte.

Top module: `twb_addr_decoder`

## Requirements
- R1: After reset, ack_vld is 0, match_type is 2'b00 (none) and rw_dir is 0.
- R2: Own 7-bit address. When the first byte after a START has bits 7:1 equal to own_addr7, the block responds one cycle after the byte strobe. In that cycle ack_vld is 1 and ack_bit is 1 (1 means acknowledge). match_type is 2'b01 and rw_dir equals bit 0 of the byte. This holds only when the address is not a reserved code (see R5).
- R3: General call. A first byte of 8'h00 is acknowledged with match_type 2'b11 and rw_dir 0 when en_gcall is 1. When en_gcall is 0 it gets ack_bit 0 and match_type 2'b00.
- R4: START byte. A first byte of 8'h01 gets ack_vld 1 with ack_bit 0, and match_type stays 2'b00.
- R5: Reserved codes always get ack_bit 0 and match_type 2'b00, even when own_addr7 equals them. These are first bytes whose upper nibble is 4'b0000 (other than 8'h00 and 8'h01) and first bytes whose bits 7:3 are 5'b11111.
- R6: A first byte that is declined gets ack_bit 0. After that, no byte produces ack_vld until the next START.
- R7: 10-bit write. A first byte 11110 followed by own_addr10[9:8], with bit 0 equal to 0, is acknowledged with match_type still 2'b00, provided en_10bit is 1. The following byte is then acknowledged with match_type 2'b10 and rw_dir 0 if it equals own_addr10[7:0]; any other value gets ack_bit 0. With en_10bit at 0 the header gets ack_bit 0.
- R8: 10-bit read. After a completed 10-bit write match, a repeated START followed by the same header with bit 0 equal to 1 is acknowledged with match_type 2'b10 and rw_dir 1. Without such a prior match, that header gets ack_bit 0.
- R9: The held 10-bit match is cleared by a STOP. It is also cleared by a START followed by any first byte other than the matching read header.
- R10: match_type and rw_dir hold their values from the acknowledge cycle while further bytes arrive. Bytes received in ST_SELECTED produce no ack_vld. A START or STOP returns match_type to 2'b00 in the cycle after the event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_evt | input | 1 | One-cycle strobe: START or repeated START seen |
| stop_evt | input | 1 | One-cycle strobe: STOP seen |
| byte_vld | input | 1 | One-cycle strobe: byte_data holds a complete received byte |
| byte_data | input | 8 | Received byte, first bit on the wire in bit 7 |
| own_addr7 | input | 7 | Own 7-bit address |
| own_addr10 | input | 10 | Own 10-bit address |
| en_10bit | input | 1 | Enables recognition of the 10-bit address |
| en_gcall | input | 1 | Enables acknowledge of the general call |
| ack_vld | output | 1 | Acknowledge decision valid (one cycle after the byte strobe) |
| ack_bit | output | 1 | 1 = acknowledge, 0 = not acknowledge |
| match_type | output | 2 | 00 none, 01 own 7-bit, 10 own 10-bit, 11 general call |
| rw_dir | output | 1 | Transfer direction of the match, 1 = read |

## Verification
The bench sweeps all 256 first-byte values with general call enabled and then disabled. Each response is compared with an arithmetic model, which catches a decoder that lets an own address override a reserved code, or that acknowledges the START byte. Each sweep step is followed by a dummy byte. This exposes a machine that keeps acknowledging after a decline, or that treats data bytes as addresses. Directed sequences target the 10-bit hold: a read header accepted without a prior write match, or kept after a STOP, a wrong low byte or an intervening 7-bit transfer. Such a design would wrongly acknowledge the read header. Further checks show whether match_type survives data bytes and clears one cycle after each START and STOP.

// File: rtl/twb_addr_pkg.sv
package twb_addr_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned A7_W    = 7;
    localparam int unsigned A10_W   = 10;
    localparam int unsigned A10HI_W = A10_W - BYTE_W;

    // Fixed code patterns on the bus
    localparam logic [BYTE_W-1:0] GCALL_CODE  = 8'h00;
    localparam logic [BYTE_W-1:0] STARTB_CODE = 8'h01;
    localparam logic [4:0]        HDR10_TAG   = 5'b11110;
    localparam logic [4:0]        FUTURE_TAG  = 5'b11111;
    localparam logic [3:0]        LOWRES_TAG  = 4'b0000;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR1,
        ST_ADDR2,
        ST_SELECTED,
        ST_IGNORE
    } rx_state_e;

    typedef enum logic [1:0] {
        MT_NONE  = 2'b00,
        MT_OWN7  = 2'b01,
        MT_OWN10 = 2'b10,
        MT_GCALL = 2'b11
    } match_e;

    typedef enum logic [2:0] {
        CLS_GCALL,
        CLS_STARTB,
        CLS_RSVD,
        CLS_HDR10,
        CLS_OWN7,
        CLS_OTHER
    } byte_cls_e;

endpackage

// File: rtl/twb_first_byte_cls.sv
module twb_first_byte_cls
    import twb_addr_pkg::*;
(
    input  logic [BYTE_W-1:0]  byte_i,
    input  logic [A7_W-1:0]    own7_i,
    input  logic [A10HI_W-1:0] own10_hi_i,
    output byte_cls_e          cls_o,
    output logic               hi_ok_o
);

    logic is_low_rsvd;
    logic is_future;
    logic is_hdr10;

    assign is_low_rsvd = (byte_i[BYTE_W-1 -: 4] == LOWRES_TAG);
    assign is_future   = (byte_i[BYTE_W-1 -: 5] == FUTURE_TAG);
    assign is_hdr10    = (byte_i[BYTE_W-1 -: 5] == HDR10_TAG);
    assign hi_ok_o     = (byte_i[A10HI_W:1] == own10_hi_i);

    // Reserved codes take priority over the own 7-bit address
    always_comb begin
        if (byte_i == GCALL_CODE) begin
            cls_o = CLS_GCALL;
        end else if (byte_i == STARTB_CODE) begin
            cls_o = CLS_STARTB;
        end else if (is_low_rsvd || is_future) begin
            cls_o = CLS_RSVD;
        end else if (is_hdr10) begin
            cls_o = CLS_HDR10;
        end else if (byte_i[BYTE_W-1:1] == own7_i) begin
            cls_o = CLS_OWN7;
        end else begin
            cls_o = CLS_OTHER;
        end
    end

endmodule

// File: rtl/twb_tenbit_hold.sv
module twb_tenbit_hold (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic hold_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_o <= 1'b0;
        end else if (clr_i) begin
            hold_o <= 1'b0;
        end else if (set_i) begin
            hold_o <= 1'b1;
        end
    end

endmodule

// File: rtl/twb_addr_decoder.sv
module twb_addr_decoder
    import twb_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              byte_vld,
    input  logic [7:0]        byte_data,
    input  logic [6:0]        own_addr7,
    input  logic [9:0]        own_addr10,
    input  logic              en_10bit,
    input  logic              en_gcall,
    output logic              ack_vld,
    output logic              ack_bit,
    output logic [1:0]        match_type,
    output logic              rw_dir
);

    rx_state_e state_q, state_d;
    match_e    mt_q, mt_d;
    logic      rw_d;
    logic      ackv_d, ack_d;
    logic      hold_set, hold_clr, hold_q;
    byte_cls_e cls;
    logic      hi_ok;
    logic      low_ok;
    logic      hdr_ok;
    logic      read_rehit;

    twb_first_byte_cls u_cls (
        .byte_i     (byte_data),
        .own7_i     (own_addr7),
        .own10_hi_i (own_addr10[A10_W-1:BYTE_W]),
        .cls_o      (cls),
        .hi_ok_o    (hi_ok)
    );

    twb_tenbit_hold u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (hold_set),
        .clr_i  (hold_clr),
        .hold_o (hold_q)
    );

    assign low_ok     = (byte_data == own_addr10[BYTE_W-1:0]);
    assign hdr_ok     = (cls == CLS_HDR10) && hi_ok && en_10bit;
    assign read_rehit = hdr_ok && byte_data[0] && hold_q;

    // Next-state and next-output decode
    always_comb begin
        state_d  = state_q;
        mt_d     = mt_q;
        rw_d     = rw_dir;
        ackv_d   = 1'b0;
        ack_d    = 1'b0;
        hold_set = 1'b0;
        hold_clr = 1'b0;
        if (stop_evt) begin
            state_d  = ST_IDLE;
            mt_d     = MT_NONE;
            rw_d     = 1'b0;
            hold_clr = 1'b1;
        end else if (start_evt) begin
            state_d = ST_ADDR1;
            mt_d    = MT_NONE;
            rw_d    = 1'b0;
        end else if (byte_vld) begin
            unique case (state_q)
                ST_ADDR1: begin
                    ackv_d   = 1'b1;
                    state_d  = ST_IGNORE;
                    hold_clr = !read_rehit;
                    unique case (cls)
                        CLS_GCALL: begin
                            if (en_gcall) begin
                                ack_d   = 1'b1;
                                mt_d    = MT_GCALL;
                                rw_d    = 1'b0;
                                state_d = ST_SELECTED;
                            end
                        end
                        CLS_HDR10: begin
                            if (read_rehit) begin
                                ack_d   = 1'b1;
                                mt_d    = MT_OWN10;
                                rw_d    = 1'b1;
                                state_d = ST_SELECTED;
                            end else if (hdr_ok && !byte_data[0]) begin
                                ack_d   = 1'b1;
                                state_d = ST_ADDR2;
                            end
                        end
                        CLS_OWN7: begin
                            ack_d   = 1'b1;
                            mt_d    = MT_OWN7;
                            rw_d    = byte_data[0];
                            state_d = ST_SELECTED;
                        end
                        CLS_STARTB, CLS_RSVD, CLS_OTHER: begin
                            ack_d = 1'b0;
                        end
                        default: begin
                            ack_d = 1'b0;
                        end
                    endcase
                end
                ST_ADDR2: begin
                    ackv_d  = 1'b1;
                    state_d = ST_IGNORE;
                    if (low_ok) begin
                        ack_d    = 1'b1;
                        mt_d     = MT_OWN10;
                        rw_d     = 1'b0;
                        hold_set = 1'b1;
                        state_d  = ST_SELECTED;
                    end
                end
                ST_IDLE, ST_SELECTED, ST_IGNORE: begin
                    state_d = state_q;
                end
                default: begin
                    state_d = ST_IDLE;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mt_q    <= MT_NONE;
            rw_dir  <= 1'b0;
            ack_vld <= 1'b0;
            ack_bit <= 1'b0;
        end else begin
            mt_q    <= mt_d;
            rw_dir  <= rw_d;
            ack_vld <= ackv_d;
            ack_bit <= ack_d;
        end
    end

    assign match_type = mt_q;

endmodule

// File: rtl/twb_addr_decoder_chk.sv
module twb_addr_decoder_chk
    import twb_addr_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       start_evt,
    input logic       stop_evt,
    input logic       byte_vld,
    input logic [7:0] byte_data,
    input logic       ack_vld,
    input logic       ack_bit,
    input logic [1:0] match_type,
    input logic       rw_dir,
    input rx_state_e  state_q
);

    AST_ACK_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_vld |-> $past(byte_vld)); // R2

    AST_EVENT_CLEARS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt || stop_evt) |=> (match_type == 2'b00)); // R10

    AST_MATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (match_type != 2'b00 && !start_evt && !stop_evt) |=> ($stable(match_type) && $stable(rw_dir))); // R10

    AST_NACK_NO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_vld && !ack_bit) |-> (match_type == 2'b00)); // R6

    AST_GCALL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (match_type == 2'b11) |-> !rw_dir); // R3

    AST_FUTURE_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !start_evt && !stop_evt && state_q == ST_ADDR1 && byte_data[7:3] == 5'b11111)
        |=> (ack_vld && !ack_bit)); // R5

    AST_STARTB_NACK: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !start_evt && !stop_evt && state_q == ST_ADDR1 && byte_data == 8'h01)
        |=> (ack_vld && !ack_bit)); // R4

    AST_QUIET_AFTER_DECIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !start_evt && !stop_evt && (state_q == ST_SELECTED || state_q == ST_IGNORE))
        |=> !ack_vld); // R6

endmodule

bind twb_addr_decoder twb_addr_decoder_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_evt  (start_evt),
    .stop_evt   (stop_evt),
    .byte_vld   (byte_vld),
    .byte_data  (byte_data),
    .ack_vld    (ack_vld),
    .ack_bit    (ack_bit),
    .match_type (match_type),
    .rw_dir     (rw_dir),
    .state_q    (state_q)
);

// File: tb/twb_addr_decoder_bench.sv
module twb_addr_decoder_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_evt = 1'b0;
    logic       stop_evt = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = 8'h00;
    logic [6:0] own_addr7 = 7'h2A;
    logic [9:0] own_addr10 = 10'h2C5;
    logic       en_10bit = 1'b1;
    logic       en_gcall = 1'b1;
    logic       ack_vld;
    logic       ack_bit;
    logic [1:0] match_type;
    logic       rw_dir;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    twb_addr_decoder u_twb_addr_decoder (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_evt  (start_evt),
        .stop_evt   (stop_evt),
        .byte_vld   (byte_vld),
        .byte_data  (byte_data),
        .own_addr7  (own_addr7),
        .own_addr10 (own_addr10),
        .en_10bit   (en_10bit),
        .en_gcall   (en_gcall),
        .ack_vld    (ack_vld),
        .ack_bit    (ack_bit),
        .match_type (match_type),
        .rw_dir     (rw_dir)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ev_start();
        @(negedge clk); start_evt = 1'b1;
        @(negedge clk); start_evt = 1'b0;
    endtask

    task automatic ev_stop();
        @(negedge clk); stop_evt = 1'b1;
        @(negedge clk); stop_evt = 1'b0;
    endtask

    // Outputs are sampled at the negedge after the registering posedge
    task automatic put_byte(input logic [7:0] b);
        @(negedge clk); byte_data = b; byte_vld = 1'b1;
        @(negedge clk); byte_vld = 1'b0;
    endtask

    task automatic expect_resp(input string req, input int av, input int ab, input int mt);
        check({req, " ack_vld"}, int'(ack_vld), av);
        check({req, " ack_bit"}, int'(ack_bit), ab);
        check({req, " match_type"}, int'(match_type), mt);
    endtask

    // Model of the first-byte decision with no held 10-bit match
    function automatic void model_first(input logic [7:0] b, input bit gc,
                                        output int ab, output int mt, output int rw,
                                        output bit to_low);
        ab = 0; mt = 0; rw = 0; to_low = 1'b0;
        if (b == 8'h00) begin
            ab = gc ? 1 : 0; mt = gc ? 3 : 0;
        end else if (b == 8'h01 || b[7:4] == 4'h0 || b[7:3] == 5'b11111) begin
            ab = 0;
        end else if (b[7:3] == 5'b11110) begin
            if (b[2:1] == own_addr10[9:8] && !b[0]) begin
                ab = 1; to_low = 1'b1;
            end
        end else if (b[7:1] == own_addr7) begin
            ab = 1; mt = 1; rw = int'(b[0]);
        end
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int ab, mt, rw;
        bit to_low;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ack_vld", int'(ack_vld), 0);
        check("R1 match_type", int'(match_type), 0);
        check("R1 rw_dir", int'(rw_dir), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", int'(match_type), 0);

        // Sweep every first byte, general call on then off (R2 R3 R4 R5 R6 R7)
        for (int g = 1; g >= 0; g--) begin
            en_gcall = g[0];
            for (int v = 0; v < 256; v++) begin
                model_first(v[7:0], g[0], ab, mt, rw, to_low);
                ev_start();
                put_byte(v[7:0]);
                expect_resp("R2_R3_R4_R5_R7 sweep", 1, ab, mt);
                if (mt != 0) check("R2_R3 sweep rw_dir", int'(rw_dir), rw);
                // dummy follow-up byte; not the own low byte
                put_byte(8'hA5);
                expect_resp("R6_R10 follow-up", to_low ? 1 : 0, 0, mt);
                ev_stop();
            end
        end
        en_gcall = 1'b1;

        // R7 full 10-bit write then R8 read re-use
        ev_start(); put_byte(8'hF4);
        expect_resp("R7 header", 1, 1, 0);
        put_byte(8'hC5);
        expect_resp("R7 low byte", 1, 1, 2);
        check("R7 rw_dir", int'(rw_dir), 0);
        put_byte(8'h33);
        expect_resp("R10 data byte", 0, 0, 2);
        ev_start();
        check("R10 start clears", int'(match_type), 0);
        put_byte(8'hF5);
        expect_resp("R8 read header", 1, 1, 2);
        check("R8 rw_dir", int'(rw_dir), 1);
        ev_stop();
        check("R10 stop clears", int'(match_type), 0);

        // R9 STOP dropped the hold
        ev_start(); put_byte(8'hF5);
        expect_resp("R9 read after stop", 1, 0, 0);
        ev_stop();

        // R9 intervening 7-bit transfer drops the hold
        ev_start(); put_byte(8'hF4); put_byte(8'hC5);
        expect_resp("R7 relock", 1, 1, 2);
        ev_start(); put_byte(8'h54);
        expect_resp("R2 7-bit under Sr", 1, 1, 1);
        ev_start(); put_byte(8'hF5);
        expect_resp("R9 read after other byte", 1, 0, 0);
        ev_stop();

        // R7 wrong low byte gives no hold
        ev_start(); put_byte(8'hF4); put_byte(8'hC4);
        expect_resp("R7 wrong low", 1, 0, 0);
        ev_start(); put_byte(8'hF5);
        expect_resp("R8 read without match", 1, 0, 0);
        ev_stop();

        // R7 10-bit disabled
        en_10bit = 1'b0;
        ev_start(); put_byte(8'hF4);
        expect_resp("R7 disabled header", 1, 0, 0);
        ev_stop();
        en_10bit = 1'b1;

        // R5 own address colliding with reserved codes
        own_addr7 = 7'h7C;
        ev_start(); put_byte(8'hF9);
        expect_resp("R5 future code own", 1, 0, 0);
        ev_stop();
        own_addr7 = 7'h04;
        ev_start(); put_byte(8'h08);
        expect_resp("R5 low reserved own", 1, 0, 0);
        ev_stop();

        // R10 held through data, R2 read direction
        own_addr7 = 7'h2A;
        ev_start(); put_byte(8'h55);
        expect_resp("R2 read", 1, 1, 1);
        for (int k = 0; k < 4; k++) begin
            put_byte(8'(k * 37));
            expect_resp("R10 held", 0, 0, 1);
            check("R10 rw held", int'(rw_dir), 1);
        end
        ev_stop();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule